// File: doc/BRIEF.md
# Strided Vector Load Engine

This block fetches one vector operand from banked word memory and delivers it, element by element, to a vector register file. A start command supplies a base word address, a signed stride and an element count. The engine generates one word address per element and sends each request to the bank chosen by that address. It holds back a request while its bank is still recovering from an earlier access. Every word comes back after a fixed latency and is written to the register file with its element index.

The banks sit inside the block as sixteen independent synchronous RAMs. A fill port loads them while the engine is idle. Requests leave in strict element order, so the register-file writes also come out in element order without any reordering storage. A level done flag tells the issuing logic that the whole vector has landed.

Top module: `vec_stride_loader`

## Requirements
- R1: Element i reads the word at address base + i*stride, taken modulo 2^ADDR_W. The stride is a two's-complement value, so a negative stride walks downward and wraps below zero.
- R2: The bank is selected by the low 4 bits of the word address. The upper bits select the row inside that bank.
- R3: A bank that accepts a request in cycle c accepts no further request before cycle c+4. Consecutive requests to one bank are therefore at least 4 cycles apart.
- R4: Requests are issued in element order, at most one per cycle. The first may issue in the cycle after the start is accepted. An element issues in the first cycle its bank is free, so issue stalls only when the bank is busy.
- R5: The word for an element appears on rf_data with rf_we high exactly 12 cycles after that element's request issued.
- R6: A load of length L raises rf_we exactly L times. rf_idx runs 0, 1, ..., L-1.
- R7: done goes high in the cycle after the last write strobe. It stays high until the next accepted start clears it.
- R8: A start with length 0 raises done in the next cycle and issues no request and no write strobe.
- R9: A length above 64 is treated as 64.
- R10: A start pulse while a load is in progress is ignored.
- R11: A fill write while the engine is idle stores fill_data at fill_addr, and later loads return it. A fill write during a load has no effect.
- R12: While reset is held, and directly after it, rf_we and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a load with the operands below |
| base | input | ADDR_W (10) | Word address of element 0 |
| stride | input | ADDR_W (10) | Signed element step in words |
| len | input | LEN_W (7) | Element count, clamped to 64 |
| fill_we | input | 1 | Write one word into the banks (idle only) |
| fill_addr | input | ADDR_W (10) | Word address for the fill write |
| fill_data | input | DATA_W (64) | Fill word |
| rf_we | output | 1 | Register-file write strobe |
| rf_idx | output | IDX_W (6) | Element index of the written word |
| rf_data | output | DATA_W (64) | Word read for that element |
| done | output | 1 | Load complete, held until next start |

## Verification
The bound checker watches the timing contract on every cycle. It confirms that no bank is hit again inside its recovery window and that every write strobe follows an issue by exactly the memory latency. It also confirms that write indices advance in order and that done only rises after a final write or a zero-length start. Whether the right word lands under each stride, whether the stall pattern produces the expected total load time, and whether an ignored start or fill really leaves data untouched can only be shown by the bench scenarios: unit, odd, same-bank, half-bank, negative and wrapping strides, zero and over-long lengths, and intrusions during a load.

// File: rtl/vsl_pkg.sv
package vsl_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} vsl_state_e;
endpackage

// File: rtl/vsl_bank_timers.sv
module vsl_bank_timers #(
  parameter int NUM_BANKS = 16,
  parameter int BUSY      = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int CNT_W    = $clog2(BUSY + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 take,
  input  logic [BANK_W-1:0]    take_bank,
  output logic [NUM_BANKS-1:0] free
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [CNT_W-1:0] left_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        left_q <= '0;
      end else if (take && take_bank == BANK_W'(b)) begin
        left_q <= CNT_W'(BUSY - 1);
      end else if (left_q != '0) begin
        left_q <= left_q - CNT_W'(1);
      end
    end
    assign free[b] = (left_q == '0);
  end
endmodule

// File: rtl/vsl_lat_pipe.sv
module vsl_lat_pipe #(
  parameter int W     = 8,
  parameter int DEPTH = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  if (DEPTH == 0) begin : g_wire
    assign q = d;
  end else begin : g_regs
    logic [W-1:0] st_q [DEPTH];
    always_ff @(posedge clk) begin
      if (rst) begin
        for (int k = 0; k < DEPTH; k++) st_q[k] <= '0;
      end else begin
        st_q[0] <= d;
        for (int k = 1; k < DEPTH; k++) st_q[k] <= st_q[k-1];
      end
    end
    assign q = st_q[DEPTH-1];
  end
endmodule

// File: rtl/vsl_bank_ram.sv
module vsl_bank_ram #(
  parameter int DATA_W = 64,
  parameter int ROWS   = 64,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ROW_W-1:0]  rd_row,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_row] <= wr_data;
    if (rd_en) rd_data <= mem[rd_row];
  end
endmodule

// File: rtl/vsl_issue_ctrl.sv
module vsl_issue_ctrl
  import vsl_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int NUM_BANKS = 16,
  parameter int MAX_VL    = 64,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int LEN_W    = $clog2(MAX_VL + 1),
  localparam int IDX_W    = $clog2(MAX_VL)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [ADDR_W-1:0]    base,
  input  logic [ADDR_W-1:0]    stride,
  input  logic [LEN_W-1:0]     len,
  input  logic [NUM_BANKS-1:0] bank_free,
  input  logic                 wb_we,
  input  logic [IDX_W-1:0]     wb_idx,
  output logic                 issue_fire,
  output logic [IDX_W-1:0]     issue_idx,
  output logic [ADDR_W-1:0]    issue_addr,
  output logic                 running,
  output logic                 done
);
  vsl_state_e        state_q;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  sent_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] stride_q;
  logic [LEN_W-1:0]  len_eff;
  logic              start_ok;
  logic              last_wb;

  assign len_eff    = (len > LEN_W'(MAX_VL)) ? LEN_W'(MAX_VL) : len;
  assign start_ok   = start && (state_q == ST_IDLE);
  assign running    = (state_q == ST_RUN);
  assign issue_fire = running && (sent_q < len_q) && bank_free[addr_q[BANK_W-1:0]];
  assign issue_idx  = sent_q[IDX_W-1:0];
  assign issue_addr = addr_q;
  assign last_wb    = wb_we && ((LEN_W'(wb_idx) + LEN_W'(1)) == len_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      len_q    <= '0;
      sent_q   <= '0;
      addr_q   <= '0;
      stride_q <= '0;
      done     <= 1'b0;
    end else if (start_ok) begin
      len_q    <= len_eff;
      sent_q   <= '0;
      addr_q   <= base;
      stride_q <= stride;
      done     <= (len_eff == '0);
      state_q  <= (len_eff == '0) ? ST_IDLE : ST_RUN;
    end else if (running) begin
      if (issue_fire) begin
        addr_q <= addr_q + stride_q;
        sent_q <= sent_q + LEN_W'(1);
      end
      if (last_wb) begin
        done    <= 1'b1;
        state_q <= ST_IDLE;
      end
    end
  end
endmodule

// File: rtl/vec_stride_loader.sv
module vec_stride_loader #(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 64,
  parameter int NUM_BANKS = 16,
  parameter int BUSY      = 4,
  parameter int MEM_LAT   = 12,
  parameter int MAX_VL    = 64,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int ROW_W    = ADDR_W - BANK_W,
  localparam int ROWS     = 1 << ROW_W,
  localparam int LEN_W    = $clog2(MAX_VL + 1),
  localparam int IDX_W    = $clog2(MAX_VL),
  localparam int PIPE_D   = MEM_LAT - 2,
  localparam int ENT_W    = 1 + IDX_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] stride,
  input  logic [LEN_W-1:0]  len,
  input  logic              fill_we,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [DATA_W-1:0] fill_data,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_idx,
  output logic [DATA_W-1:0] rf_data,
  output logic              done
);
  typedef struct packed {
    logic              vld;
    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] addr;
  } req_t;

  logic [NUM_BANKS-1:0] bank_free;
  logic                 issue_fire;
  logic [IDX_W-1:0]     issue_idx;
  logic [ADDR_W-1:0]    issue_addr;
  logic [BANK_W-1:0]    issue_bank;
  logic                 running;
  logic                 fill_ok;
  req_t                 req_in;
  req_t                 req_tap;
  logic                 hold_vld;
  logic [IDX_W-1:0]     hold_idx;
  logic [BANK_W-1:0]    hold_bank;
  logic [DATA_W-1:0]    bank_q [NUM_BANKS];

  assign issue_bank = issue_addr[BANK_W-1:0];
  assign fill_ok    = fill_we && !running;

  vsl_issue_ctrl #(
    .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .MAX_VL(MAX_VL)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .base(base), .stride(stride),
    .len(len), .bank_free(bank_free), .wb_we(rf_we), .wb_idx(rf_idx),
    .issue_fire(issue_fire), .issue_idx(issue_idx), .issue_addr(issue_addr),
    .running(running), .done(done)
  );

  vsl_bank_timers #(
    .NUM_BANKS(NUM_BANKS), .BUSY(BUSY)
  ) u_timers (
    .clk(clk), .rst(rst), .take(issue_fire), .take_bank(issue_bank),
    .free(bank_free)
  );

  assign req_in = '{vld: issue_fire, idx: issue_idx, addr: issue_addr};

  vsl_lat_pipe #(
    .W(ENT_W), .DEPTH(PIPE_D)
  ) u_pipe (
    .clk(clk), .rst(rst), .d(req_in), .q(req_tap)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    vsl_bank_ram #(
      .DATA_W(DATA_W), .ROWS(ROWS)
    ) u_ram (
      .clk(clk),
      .wr_en(fill_ok && fill_addr[BANK_W-1:0] == BANK_W'(b)),
      .wr_row(fill_addr[ADDR_W-1:BANK_W]),
      .wr_data(fill_data),
      .rd_en(req_tap.vld && req_tap.addr[BANK_W-1:0] == BANK_W'(b)),
      .rd_row(req_tap.addr[ADDR_W-1:BANK_W]),
      .rd_data(bank_q[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_vld  <= 1'b0;
      hold_idx  <= '0;
      hold_bank <= '0;
      rf_we     <= 1'b0;
      rf_idx    <= '0;
      rf_data   <= '0;
    end else begin
      hold_vld  <= req_tap.vld;
      hold_idx  <= req_tap.idx;
      hold_bank <= req_tap.addr[BANK_W-1:0];
      rf_we     <= hold_vld;
      rf_idx    <= hold_idx;
      if (hold_vld) rf_data <= bank_q[hold_bank];
    end
  end
endmodule

// File: rtl/vsl_checker.sv
module vsl_checker #(
  parameter int NUM_BANKS = 16,
  parameter int BUSY      = 4,
  parameter int MEM_LAT   = 12,
  parameter int IDX_W     = 6,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int CW       = $clog2(BUSY + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              running,
  input logic              issue_fire,
  input logic [BANK_W-1:0] issue_bank,
  input logic              rf_we,
  input logic [IDX_W-1:0]  rf_idx,
  input logic              done
);
  logic [CW-1:0]      gap_q [NUM_BANKS];
  logic [MEM_LAT-1:0] fire_sh_q;
  logic [IDX_W-1:0]   next_idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < NUM_BANKS; b++) gap_q[b] <= '0;
      fire_sh_q  <= '0;
      next_idx_q <= '0;
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (issue_fire && issue_bank == BANK_W'(b)) gap_q[b] <= CW'(BUSY - 1);
        else if (gap_q[b] != '0) gap_q[b] <= gap_q[b] - CW'(1);
      end
      fire_sh_q <= {fire_sh_q[MEM_LAT-2:0], issue_fire};
      if (start && !running) next_idx_q <= '0;
      else if (rf_we) next_idx_q <= next_idx_q + IDX_W'(1);
    end
  end

  // R3: no request reaches a bank inside its recovery window
  a_r3_bank_recovery: assert property (@(posedge clk) disable iff (rst)
    issue_fire |-> gap_q[issue_bank] == '0);

  // R5: every write strobe trails an issue by exactly the latency
  a_r5_fixed_latency: assert property (@(posedge clk) disable iff (rst)
    rf_we == fire_sh_q[MEM_LAT-1]);

  // R6: writes come back in element order
  a_r6_index_order: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> rf_idx == next_idx_q);

  // R6: no write strobe outside a load
  a_r6_no_idle_write: assert property (@(posedge clk) disable iff (rst)
    !running |-> !rf_we);

  // R7/R8: done rises only after a final write or a zero-length start
  a_r7_done_source: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(rf_we) || $past(start && !running)));

  // R7: done and a write strobe never coincide
  a_r7_done_quiet: assert property (@(posedge clk) disable iff (rst)
    done |-> !rf_we);
endmodule

bind vec_stride_loader vsl_checker #(
  .NUM_BANKS(NUM_BANKS), .BUSY(BUSY), .MEM_LAT(MEM_LAT), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .running(running),
  .issue_fire(issue_fire), .issue_bank(issue_bank),
  .rf_we(rf_we), .rf_idx(rf_idx), .done(done)
);

// File: tb/vec_stride_loader_tb.sv
module vec_stride_loader_tb;
  localparam int AW = 10;
  localparam int DW = 64;
  localparam int WORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] base = '0;
  logic [AW-1:0] stride = '0;
  logic [6:0]    len = '0;
  logic          fill_we = 1'b0;
  logic [AW-1:0] fill_addr = '0;
  logic [DW-1:0] fill_data = '0;
  logic          rf_we;
  logic [5:0]    rf_idx;
  logic [DW-1:0] rf_data;
  logic          done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [DW-1:0] mirror [WORDS];
  int            exp_idx [$];
  logic [DW-1:0] exp_dat [$];

  always #2.5 clk = ~clk;

  vec_stride_loader u_dut (
    .clk(clk), .rst(rst), .start(start), .base(base), .stride(stride),
    .len(len), .fill_we(fill_we), .fill_addr(fill_addr), .fill_data(fill_data),
    .rf_we(rf_we), .rf_idx(rf_idx), .rf_data(rf_data), .done(done)
  );

  function automatic logic [DW-1:0] pat(input int a);
    return {32'hC0DE_0000 | 32'(a), 32'h5A5A_5A5A ^ (32'(a) * 32'h9E37)};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: R1 R2 data and R6 order
  always @(negedge clk) begin
    if (!rst && rf_we) begin
      if (exp_idx.size() == 0) begin
        check(1'b0, "R6", "unexpected write strobe", longint'(rf_idx), -1);
      end else begin
        int ei;
        logic [DW-1:0] ed;
        ei = exp_idx.pop_front();
        ed = exp_dat.pop_front();
        check(int'(rf_idx) == ei, "R6", "element index", longint'(rf_idx), longint'(ei));
        check(rf_data == ed, "R1", "element data", longint'(rf_data), longint'(ed));
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // expected start-to-done cycles from R3 R4 R5 R7 R8
  function automatic int exp_cycles(input logic [AW-1:0] b0, input int st, input int n);
    int free_at [16];
    int t = 1;
    int last = 0;
    for (int k = 0; k < 16; k++) free_at[k] = 0;
    if (n == 0) return 1;
    for (int i = 0; i < n; i++) begin
      logic [AW-1:0] a;
      a = b0 + AW'(i * st);
      if (t < free_at[a[3:0]]) t = free_at[a[3:0]];
      last = t;
      free_at[a[3:0]] = t + 4;
      t++;
    end
    return last + 13;
  endfunction

  task automatic fill_word(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    fill_we = 1'b1; fill_addr = AW'(a); fill_data = d;
    mirror[a] = d;
    @(negedge clk);
    fill_we = 1'b0;
  endtask

  task automatic run_load(input logic [AW-1:0] b0, input int st, input int n,
                          input string tag, input bit intrude);
    int neff;
    int want;
    int cnt;
    neff = (n > 64) ? 64 : n;
    for (int i = 0; i < neff; i++) begin
      logic [AW-1:0] a;
      a = b0 + AW'(i * st);
      exp_idx.push_back(i);
      exp_dat.push_back(mirror[a]);
    end
    want = exp_cycles(b0, st, neff);
    @(negedge clk);
    start = 1'b1; base = b0; stride = AW'(st); len = 7'(n);
    @(posedge clk);
    cnt = 1;
    @(negedge clk);
    start = 1'b0;
    while (!done && cnt < 2000) begin
      if (intrude && cnt == 3) begin
        start = 1'b1; base = 10'd500; stride = 10'd7; len = 7'd5;  // R10
      end else begin
        start = 1'b0;
      end
      if (intrude && cnt == 5) begin  // R11: fill during a load
        fill_we = 1'b1; fill_addr = b0 + AW'(15 * st); fill_data = 64'hDEAD_BEEF_0BAD_F00D;
      end else begin
        fill_we = 1'b0;
      end
      @(posedge clk);
      cnt++;
      @(negedge clk);
    end
    start = 1'b0;
    fill_we = 1'b0;
    check(cnt == want, "R4", {tag, " start-to-done cycles (R3 R5 R7)"}, cnt, want);
    check(exp_idx.size() == 0, "R6", {tag, " strobes outstanding at done"}, exp_idx.size(), 0);
    exp_idx.delete();
    exp_dat.delete();
    repeat (3) @(negedge clk);
    check(done == 1'b1, "R7", {tag, " done held"}, done, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(rf_we == 1'b0 && done == 1'b0, "R12", "outputs in reset", {rf_we, done}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(rf_we == 1'b0 && done == 1'b0, "R12", "outputs after reset", {rf_we, done}, 0);

    for (int a = 0; a < WORDS; a++) begin
      @(negedge clk);
      fill_we = 1'b1; fill_addr = AW'(a); fill_data = pat(a);
      mirror[a] = pat(a);
    end
    @(negedge clk);
    fill_we = 1'b0;

    run_load(10'd0,   1,  64, "R1 unit stride full length", 1'b0);
    run_load(10'd7,   3,  20, "R1 stride 3", 1'b0);
    run_load(10'd5,   16, 10, "R2 R3 stride 16 single bank", 1'b0);
    run_load(10'd2,   8,  9,  "R2 R3 stride 8 two banks", 1'b0);
    run_load(10'd40,  -5, 30, "R1 negative stride wrap", 1'b0);
    run_load(10'd9,   0,  5,  "R3 stride 0 same word", 1'b0);
    run_load(10'd100, 1,  0,  "R8 zero length", 1'b0);
    run_load(10'd1000, 1, 100, "R9 clamp and R1 top wrap", 1'b0);
    run_load(10'd200, 1,  20, "R10 R11 intrusions", 1'b1);
    // R11: the ignored fill left the word untouched
    run_load(10'd215, 1,  1,  "R11 word after ignored fill", 1'b0);
    // R11: an idle fill takes effect
    fill_word(333, 64'h0123_4567_89AB_CDEF);
    run_load(10'd333, 2,  3,  "R11 word after idle fill", 1'b0);

    repeat (20) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule